// File: doc/BRIEF.md
# Shared External Memory Bus Controller

This block lets a core with two separate internal memory spaces, program memory and data memory, reach off-chip memory over one address bus and one data bus. Each space presents a one-cycle request carrying an address, write data and a read/write flag. The block holds each request in a slot of its own. It grants one slot at a time and then runs a strobe window of programmable length on the shared pins. Reads return the sampled data word to the requesting space, with a one-cycle completion pulse.

Each space has its own active-low chip select, so program and data devices can share the address and data lines. The address and data pins are described as three-state buses. At the block edge each bus is an output value plus an output enable, and the data bus also has an input value, so that the pad ring or the board logic can build the actual three-state drivers. The buses float whenever no external access is in progress. This includes all the time the core executes from internal memory, because requests arriving in that condition are dropped. A busy output holds the core while an external access is pending or running.

Top module: `ext_mem_bus`

## Requirements
- R1: During and directly after synchronous reset, both selects and both strobes are high (inactive), busy and both completion pulses are low, and neither bus enable is set.
- R2: A read drives rd_n low, with wr_n high and the data enable off, for exactly WAIT+1 cycles. The word on ext_data_i in the last cycle of that window is returned on the space's read-data output.
- R3: A write drives wr_n low for exactly WAIT+1 cycles. ext_data_oe is set only in those cycles, and ext_data_o then carries the write data.
- R4: Program accesses assert only pm_sel_n and data accesses assert only dm_sel_n. A data write places its DM_DW-bit value in the low bits of the bus with the upper bits zero. A data read returns the low DM_DW bits of the bus.
- R5: pm_sel_n and dm_sel_n are never low together, and rd_n and wr_n are never low together.
- R6: When both spaces request in the same cycle, the program access runs first. The data access starts two cycles after the program strobe window ends.
- R7: busy rises in the cycle after a request is accepted and falls together with the completion pulse. Requests presented while busy is high are ignored.
- R8: Requests presented while int_exec is high are dropped: no select, strobe or bus enable follows.
- R9: ext_addr_oe is set exactly while a select is low, and ext_addr_o then carries the access address. Outside accesses both buses float.
- R10: For a request sampled at clock edge E, the select and strobe go low after edge E+1. The completion pulse is high for the single cycle after edge E+WAIT+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_exec | input | 1 | Core executes from internal memory; requests are dropped |
| pm_req | input | 1 | Program-space request, one cycle |
| pm_we | input | 1 | Program-space write when 1, read when 0 |
| pm_addr | input | AW | Program-space address |
| pm_wdata | input | PM_DW | Program-space write data |
| dm_req | input | 1 | Data-space request, one cycle |
| dm_we | input | 1 | Data-space write when 1, read when 0 |
| dm_addr | input | AW | Data-space address |
| dm_wdata | input | DM_DW | Data-space write data |
| busy | output | 1 | Stall: access pending or running |
| pm_done | output | 1 | Program access finished (one-cycle pulse) |
| pm_rdata | output | PM_DW | Program-space read data |
| dm_done | output | 1 | Data access finished (one-cycle pulse) |
| dm_rdata | output | DM_DW | Data-space read data |
| ext_addr_o | output | AW | External address value |
| ext_addr_oe | output | 1 | External address drive enable |
| ext_data_o | output | PM_DW | External data out value |
| ext_data_oe | output | 1 | External data drive enable |
| ext_data_i | input | PM_DW | External data in value |
| pm_sel_n | output | 1 | Program-memory select, active low |
| dm_sel_n | output | 1 | Data-memory select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
A corrupted wait counter shows at the pins at once: the strobe window is longer or shorter than WAIT+1 cycles, and the completion pulse moves from its expected cycle. A wrong space bit or a wrong grant choice shows as the wrong select going low, or as the data access running before the program one, in the first strobe cycle of the access. A pending slot that is not cleared or not set shows within two cycles, as a repeated access or as no select at all, and busy stays in the wrong state.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;
  typedef enum logic {
    SP_PM = 1'b0,
    SP_DM = 1'b1
  } space_e;
endpackage

// File: rtl/ext_bus_slot.sv
module ext_bus_slot #(
  parameter int AW = 14,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          clear,
  input  logic          we_in,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  output logic          pend,
  output logic          we_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      pend    <= 1'b1;
      we_q    <= we_in;
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end else if (clear) begin
      pend <= 1'b0;
    end
  end

  // R7: a slot is never loaded while it still holds an unserved request
  a_r7_no_reload: assert property (@(posedge clk) disable iff (rst)
    pend |-> !take);
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ext_bus_pkg::*;
#(
  parameter int AW    = 14,
  parameter int PM_DW = 24,
  parameter int DM_DW = 16,
  parameter int WAIT  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pm_pend,
  input  logic             pm_we,
  input  logic [AW-1:0]    pm_addr,
  input  logic [PM_DW-1:0] pm_wdata,
  input  logic             dm_pend,
  input  logic             dm_we,
  input  logic [AW-1:0]    dm_addr,
  input  logic [DM_DW-1:0] dm_wdata,
  input  logic [PM_DW-1:0] din,
  output logic             pm_grant,
  output logic             dm_grant,
  output logic             active,
  output logic [AW-1:0]    addr_q,
  output logic             addr_oe,
  output logic [PM_DW-1:0] dout_q,
  output logic             dout_oe,
  output logic             pm_sel_n,
  output logic             dm_sel_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic             pm_done,
  output logic             dm_done,
  output logic [PM_DW-1:0] rdata_q
);
  localparam int CW = (WAIT > 0) ? $clog2(WAIT + 1) : 1;
  localparam int RW = CW + 1;

  space_e        space_q;
  logic [CW-1:0] cnt_q;
  logic          start_we;

  // Program space wins whenever both slots are pending
  assign pm_grant = !active && pm_pend;
  assign dm_grant = !active && !pm_pend && dm_pend;
  assign start_we = pm_pend ? pm_we : dm_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      space_q  <= SP_PM;
      cnt_q    <= '0;
      addr_q   <= '0;
      addr_oe  <= 1'b0;
      dout_q   <= '0;
      dout_oe  <= 1'b0;
      pm_sel_n <= 1'b1;
      dm_sel_n <= 1'b1;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      pm_done  <= 1'b0;
      dm_done  <= 1'b0;
      rdata_q  <= '0;
    end else begin
      pm_done <= 1'b0;
      dm_done <= 1'b0;
      if (!active) begin
        if (pm_grant || dm_grant) begin
          active   <= 1'b1;
          space_q  <= pm_grant ? SP_PM : SP_DM;
          addr_q   <= pm_grant ? pm_addr : dm_addr;
          dout_q   <= pm_grant ? pm_wdata : PM_DW'(dm_wdata);
          addr_oe  <= 1'b1;
          dout_oe  <= start_we;
          pm_sel_n <= !pm_grant;
          dm_sel_n <= !dm_grant;
          rd_n     <= start_we;
          wr_n     <= !start_we;
          cnt_q    <= CW'(WAIT);
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        active   <= 1'b0;
        addr_oe  <= 1'b0;
        dout_oe  <= 1'b0;
        pm_sel_n <= 1'b1;
        dm_sel_n <= 1'b1;
        rd_n     <= 1'b1;
        wr_n     <= 1'b1;
        if (!rd_n) rdata_q <= din;
        if (space_q == SP_PM) pm_done <= 1'b1;
        else                  dm_done <= 1'b1;
      end
    end
  end

  // Run-length counter of the strobe window, used only by the checks below
  logic          strb_low;
  logic [RW-1:0] run_q;
  assign strb_low = !rd_n || !wr_n;
  always_ff @(posedge clk) begin
    if (rst)           run_q <= '0;
    else if (strb_low) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  a_r2_strobe_width: assert property (@(posedge clk) disable iff (rst)
    (!strb_low && $past(strb_low)) |-> (run_q == RW'(WAIT + 1)));
  a_r5_one_select: assert property (@(posedge clk) disable iff (rst)
    !(!pm_sel_n && !dm_sel_n));
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  a_r3_oe_in_write: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> !wr_n);
  a_r9_addr_with_select: assert property (@(posedge clk) disable iff (rst)
    addr_oe == (!pm_sel_n || !dm_sel_n));
  a_r6_pm_first: assert property (@(posedge clk) disable iff (rst)
    (!active && pm_pend && dm_pend) |=> (!pm_sel_n && dm_sel_n));
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    (pm_done || dm_done) |=> !(pm_done || dm_done));
endmodule

// File: rtl/ext_mem_bus.sv
module ext_mem_bus #(
  parameter int AW    = 14,
  parameter int PM_DW = 24,
  parameter int DM_DW = 16,
  parameter int WAIT  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             int_exec,
  input  logic             pm_req,
  input  logic             pm_we,
  input  logic [AW-1:0]    pm_addr,
  input  logic [PM_DW-1:0] pm_wdata,
  input  logic             dm_req,
  input  logic             dm_we,
  input  logic [AW-1:0]    dm_addr,
  input  logic [DM_DW-1:0] dm_wdata,
  output logic             busy,
  output logic             pm_done,
  output logic [PM_DW-1:0] pm_rdata,
  output logic             dm_done,
  output logic [DM_DW-1:0] dm_rdata,
  output logic [AW-1:0]    ext_addr_o,
  output logic             ext_addr_oe,
  output logic [PM_DW-1:0] ext_data_o,
  output logic             ext_data_oe,
  input  logic [PM_DW-1:0] ext_data_i,
  output logic             pm_sel_n,
  output logic             dm_sel_n,
  output logic             rd_n,
  output logic             wr_n
);
  logic             accept;
  logic             pm_pend, dm_pend, pm_grant, dm_grant, active;
  logic             pm_we_q, dm_we_q;
  logic [AW-1:0]    pm_addr_q, dm_addr_q;
  logic [PM_DW-1:0] pm_wdata_q, rdata_q;
  logic [DM_DW-1:0] dm_wdata_q;

  assign busy   = pm_pend || dm_pend || active;
  assign accept = !int_exec && !busy;

  ext_bus_slot #(.AW(AW), .DW(PM_DW)) u_pm_slot (
    .clk(clk), .rst(rst), .take(pm_req && accept), .clear(pm_grant),
    .we_in(pm_we), .addr_in(pm_addr), .wdata_in(pm_wdata),
    .pend(pm_pend), .we_q(pm_we_q), .addr_q(pm_addr_q), .wdata_q(pm_wdata_q)
  );

  ext_bus_slot #(.AW(AW), .DW(DM_DW)) u_dm_slot (
    .clk(clk), .rst(rst), .take(dm_req && accept), .clear(dm_grant),
    .we_in(dm_we), .addr_in(dm_addr), .wdata_in(dm_wdata),
    .pend(dm_pend), .we_q(dm_we_q), .addr_q(dm_addr_q), .wdata_q(dm_wdata_q)
  );

  ext_bus_seq #(.AW(AW), .PM_DW(PM_DW), .DM_DW(DM_DW), .WAIT(WAIT)) u_seq (
    .clk(clk), .rst(rst),
    .pm_pend(pm_pend), .pm_we(pm_we_q), .pm_addr(pm_addr_q), .pm_wdata(pm_wdata_q),
    .dm_pend(dm_pend), .dm_we(dm_we_q), .dm_addr(dm_addr_q), .dm_wdata(dm_wdata_q),
    .din(ext_data_i),
    .pm_grant(pm_grant), .dm_grant(dm_grant), .active(active),
    .addr_q(ext_addr_o), .addr_oe(ext_addr_oe),
    .dout_q(ext_data_o), .dout_oe(ext_data_oe),
    .pm_sel_n(pm_sel_n), .dm_sel_n(dm_sel_n), .rd_n(rd_n), .wr_n(wr_n),
    .pm_done(pm_done), .dm_done(dm_done), .rdata_q(rdata_q)
  );

  assign pm_rdata = rdata_q;
  assign dm_rdata = rdata_q[DM_DW-1:0];

  // R8: a slot only fills when the core was not executing internally
  a_r8_pm_take_external: assert property (@(posedge clk) disable iff (rst)
    $rose(pm_pend) |-> $past(!int_exec));
  a_r8_dm_take_external: assert property (@(posedge clk) disable iff (rst)
    $rose(dm_pend) |-> $past(!int_exec));
  // R7: busy drops exactly when an access completes
  a_r7_busy_ends_on_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (pm_done || dm_done));
endmodule

// File: tb/ext_mem_bus_test.sv
`timescale 1ns/1ps
module ext_mem_bus_test;
  localparam int AW = 14, PDW = 24, DDW = 16, WAIT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic int_exec = 1'b0;
  logic pm_req = 1'b0, pm_we = 1'b0, dm_req = 1'b0, dm_we = 1'b0;
  logic [AW-1:0]  pm_addr = '0, dm_addr = '0;
  logic [PDW-1:0] pm_wdata = '0;
  logic [DDW-1:0] dm_wdata = '0;
  logic busy, pm_done, dm_done, ext_addr_oe, ext_data_oe;
  logic pm_sel_n, dm_sel_n, rd_n, wr_n;
  logic [PDW-1:0] pm_rdata, ext_data_o, ext_data_i;
  logic [DDW-1:0] dm_rdata;
  logic [AW-1:0]  ext_addr_o;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ext_mem_bus #(.AW(AW), .PM_DW(PDW), .DM_DW(DDW), .WAIT(WAIT)) uut (
    .clk(clk), .rst(rst), .int_exec(int_exec),
    .pm_req(pm_req), .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
    .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .busy(busy), .pm_done(pm_done), .pm_rdata(pm_rdata),
    .dm_done(dm_done), .dm_rdata(dm_rdata),
    .ext_addr_o(ext_addr_o), .ext_addr_oe(ext_addr_oe),
    .ext_data_o(ext_data_o), .ext_data_oe(ext_data_oe), .ext_data_i(ext_data_i),
    .pm_sel_n(pm_sel_n), .dm_sel_n(dm_sel_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  // External memory model: 16 words per space
  logic [PDW-1:0] pm_mem [16];
  logic [PDW-1:0] dm_mem [16];

  function automatic logic [PDW-1:0] pm_init(input int i);
    return 24'hA50000 + 24'(i * 'h111);
  endfunction
  function automatic logic [PDW-1:0] dm_init(input int i);
    return 24'h3CC300 + 24'(i * 'h21);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) begin
        pm_mem[i] <= pm_init(i);
        dm_mem[i] <= dm_init(i);
      end
    end else if (!wr_n && ext_data_oe) begin
      if (!pm_sel_n) pm_mem[ext_addr_o[3:0]] <= ext_data_o;
      if (!dm_sel_n) dm_mem[ext_addr_o[3:0]] <= ext_data_o;
    end
  end

  always_comb begin
    if (!rd_n && !pm_sel_n)      ext_data_i = pm_mem[ext_addr_o[3:0]];
    else if (!rd_n && !dm_sel_n) ext_data_i = dm_mem[ext_addr_o[3:0]];
    else                         ext_data_i = 24'h0;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 pm_sel_n idle", int'(pm_sel_n), 1);
    chk("R1 dm_sel_n idle", int'(dm_sel_n), 1);
    chk("R1 strobes idle", int'({rd_n, wr_n}), 3);
    chk("R1 busy low", int'(busy), 0);
    chk("R1 done low", int'({pm_done, dm_done}), 0);
    chk("R9 buses float in reset", int'({ext_addr_oe, ext_data_oe}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after release", int'({pm_sel_n, dm_sel_n, rd_n, wr_n, busy}), 5'b11110);
  endtask

  // One access on either space, checked cycle by cycle
  task automatic t_access(input bit dm, input bit we, input logic [AW-1:0] a,
                          input logic [PDW-1:0] wd, input logic [PDW-1:0] exp);
    logic [PDW-1:0] bus_wd;
    bus_wd = dm ? {8'h0, wd[15:0]} : wd;
    @(negedge clk);
    if (dm) begin dm_req = 1'b1; dm_we = we; dm_addr = a; dm_wdata = wd[15:0]; end
    else    begin pm_req = 1'b1; pm_we = we; pm_addr = a; pm_wdata = wd; end
    @(negedge clk);
    pm_req = 1'b0; dm_req = 1'b0;
    chk("R7 busy after accept", int'(busy), 1);
    chk("R10 no select yet", int'({pm_sel_n, dm_sel_n}), 3);
    for (int k = 0; k <= WAIT; k++) begin
      @(negedge clk);
      chk("R4 select of space", int'({pm_sel_n, dm_sel_n}), dm ? 2'b10 : 2'b01);
      chk("R9 address driven", int'({ext_addr_oe, ext_addr_o}), int'({1'b1, a}));
      if (we) begin
        chk("R3 write strobe", int'({rd_n, wr_n, ext_data_oe}), 3'b101);
        chk("R4 write data on bus", int'(ext_data_o), int'(bus_wd));
      end else begin
        chk("R2 read strobe", int'({rd_n, wr_n, ext_data_oe}), 3'b010);
      end
    end
    @(negedge clk);
    chk("R10 done pulse", int'({pm_done, dm_done}), dm ? 2'b01 : 2'b10);
    chk("R2 strobes released", int'({pm_sel_n, dm_sel_n, rd_n, wr_n}), 4'hF);
    chk("R9 buses float after", int'({ext_addr_oe, ext_data_oe}), 0);
    chk("R7 busy drops with done", int'(busy), 0);
    if (!we) begin
      if (dm) chk("R4 dm read data", int'(dm_rdata), int'(exp[15:0]));
      else    chk("R2 pm read data", int'(pm_rdata), int'(exp));
    end else begin
      if (dm) chk("R4 dm stored word", int'(dm_mem[a[3:0]]), int'(bus_wd));
      else    chk("R3 pm stored word", int'(pm_mem[a[3:0]]), int'(wd));
    end
    @(negedge clk);
    chk("R10 done lasts one cycle", int'({pm_done, dm_done}), 0);
  endtask

  task automatic t_both();
    @(negedge clk);
    pm_req = 1'b1; pm_we = 1'b0; pm_addr = 14'd3;
    dm_req = 1'b1; dm_we = 1'b0; dm_addr = 14'd5;
    for (int n = 1; n <= 2 * WAIT + 6; n++) begin
      @(negedge clk);
      pm_req = 1'b0; dm_req = 1'b0;
      chk("R6 pm select order", int'(pm_sel_n), (n >= 2 && n <= WAIT + 2) ? 0 : 1);
      chk("R6 dm select order", int'(dm_sel_n), (n >= WAIT + 4 && n <= 2 * WAIT + 4) ? 0 : 1);
      chk("R5 selects exclusive", int'(!pm_sel_n && !dm_sel_n), 0);
      if (n == WAIT + 3) chk("R6 pm data first", int'(pm_rdata), int'(pm_init(3)));
      if (n == 2 * WAIT + 5) begin
        chk("R6 dm done last", int'(dm_done), 1);
        chk("R6 dm data", int'(dm_rdata), int'(dm_init(5) & 24'hFFFF));
      end
    end
  endtask

  task automatic t_busy_ignore();
    @(negedge clk);
    pm_req = 1'b1; pm_we = 1'b0; pm_addr = 14'd1;
    @(negedge clk);
    pm_req = 1'b0;
    @(negedge clk);
    pm_req = 1'b1; pm_addr = 14'd9; dm_req = 1'b1; dm_we = 1'b1; dm_addr = 14'd2;
    @(negedge clk);
    pm_req = 1'b0; dm_req = 1'b0;
    chk("R7 address kept while busy", int'(ext_addr_o), 1);
    repeat (WAIT) @(negedge clk);
    chk("R7 first access done", int'(pm_done), 1);
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      chk("R7 busy request ignored", int'({busy, pm_sel_n, dm_sel_n, wr_n}), 4'b0111);
    end
    chk("R7 dm word untouched", int'(dm_mem[2]), int'(dm_init(2)));
  endtask

  task automatic t_internal();
    @(negedge clk);
    int_exec = 1'b1;
    pm_req = 1'b1; pm_we = 1'b1; pm_addr = 14'd6; pm_wdata = 24'h777777;
    dm_req = 1'b1; dm_we = 1'b0; dm_addr = 14'd6;
    @(negedge clk);
    pm_req = 1'b0; dm_req = 1'b0;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      chk("R8 internal request dropped", int'({busy, pm_sel_n, dm_sel_n, rd_n, wr_n}), 5'b01111);
      chk("R8 buses float internal", int'({ext_addr_oe, ext_data_oe}), 0);
    end
    chk("R8 pm word untouched", int'(pm_mem[6]), int'(pm_init(6)));
    int_exec = 1'b0;
  endtask

  initial begin
    t_reset();
    t_access(1'b0, 1'b0, 14'd2, 24'h0, pm_init(2));
    t_access(1'b0, 1'b1, 14'd7, 24'h13579B, 24'h0);
    t_access(1'b0, 1'b0, 14'd7, 24'h0, 24'h13579B);
    t_access(1'b1, 1'b1, 14'h2A4, 24'hFFBEEF, 24'h0);
    t_access(1'b1, 1'b0, 14'h2A4, 24'h0, 24'h00BEEF);
    t_both();
    t_busy_ignore();
    t_internal();
    t_access(1'b1, 1'b0, 14'd11, 24'h0, dm_init(11));
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule